// File: doc/BRIEF.md
# Scalar Branch and Jump Resolver

This block decides the control-flow outcome of one instruction in the read/execute stage of a small scalar core. Its instruction memory spans 4 KiB. Each cycle it may be offered an instruction word, the two source operands already read from the register file, and the word-aligned program counter of that instruction. One clock edge later it presents four results. The first says whether control flow is redirected. The second is the address to fetch next. The last two say whether a return address has to be written, and to which register and with what value.

It covers the conditional branches: equal, not equal, sign tests on one operand with and without linking, and the greater-than-zero and less-or-equal-zero tests. It also covers the direct jumps (J, JAL) and the register-indirect jumps (JR, JALR). Each target and each return address is reduced to a 12-bit word address. Arithmetic that runs past the top of the space comes back in at the bottom, and the reverse also holds. Any other instruction word yields the sequential address and no link write. The fetch stage, the register file and hazard logic sit outside this block.

The results are registered. The block only loads them on a cycle in which the input is marked valid, and it holds them at every other cycle.

Top module: `branch_unit`

## Requirements
- R1: While reset is asserted and after it is released, before any valid input, out_valid, taken, next_pc, link_we, link_idx and link_val are all zero.
- R2: out_valid equals in_valid delayed by one clock. The results appear one clock after a cycle with in_valid high. They keep their values through any cycle with in_valid low, whatever the other inputs do.
- R3: For opcode 4 (bits 31:26), the branch is taken when op_a equals op_b. For opcode 5 it is taken when they differ. The taken target is (pc + 4 + sign-extended bits 15:0 times 4) AND 0xFFC, wrapping modulo 4096 in both directions.
- R4: For opcode 1 with bits 20:16 in {0, 1, 16, 17}, the condition is on the sign bit of op_a. Bit 16 set means take when op_a is non-negative. Bit 16 clear means take when op_a is negative. The target is formed as in R3.
- R5: For opcode 6 the branch is taken when op_a, read as signed, is at most zero. For opcode 7 it is taken when op_a is greater than zero. The target is formed as in R3.
- R6: For opcode 1 with bit 20 set (bits 20:16 equal to 16 or 17), link_we is 1, link_idx is 31 and link_val is (pc + 8) AND 0xFFC. This holds whether or not the branch is taken.
- R7: Opcode 2 and opcode 3 are always taken, with target (instr << 2) AND 0xFFC. Opcode 3 also writes (pc + 8) AND 0xFFC to register 31. Opcode 2 writes no link.
- R8: Opcode 0 with function field (bits 5:0) 8 or 9 is always taken, with target op_a AND 0xFFC. Function 9 writes (pc + 8) AND 0xFFC to the register named by bits 15:11.
- R9: When no redirect happens, taken is 0 and next_pc is (pc + 4) AND 0xFFC, so 0xFFC is followed by 0x000. This covers a branch that is not taken and any word not listed in R3 to R8.
- R10: When no link write is required, link_we is 0 and both link_idx and link_val are driven as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction on the inputs is to be resolved this cycle |
| instr | input | 32 | Instruction word |
| op_a | input | 32 | First source operand |
| op_b | input | 32 | Second source operand |
| pc | input | 12 | Word-aligned address of the instruction |
| out_valid | output | 1 | Results below belong to an instruction offered last cycle |
| taken | output | 1 | Control flow is redirected |
| next_pc | output | 12 | Next fetch address |
| link_we | output | 1 | A return address must be written |
| link_idx | output | 5 | Destination register of the return address |
| link_val | output | 12 | Return address |

## Verification
The properties assume that pc always arrives word-aligned. They also assume that in_valid is only a request to resolve, with no handshake back. Under those two conditions the sequential-address and indirect-target checks can compare outputs directly with the registered inputs. The stimulus only offers program counters that are multiples of four. It sweeps them across the whole 4 KiB space, including 0x000 and 0xFFC. It drives in_valid for exactly one cycle per instruction, with idle gaps between. The operand values are chosen to sit on the sign and zero boundaries that the comparisons depend on.

// File: rtl/bru_pkg.sv
package bru_pkg;
  localparam int unsigned OPC_W = 6;

  localparam logic [OPC_W-1:0] OPC_SPECIAL = 6'd0;
  localparam logic [OPC_W-1:0] OPC_REGIMM  = 6'd1;
  localparam logic [OPC_W-1:0] OPC_J       = 6'd2;
  localparam logic [OPC_W-1:0] OPC_JAL     = 6'd3;
  localparam logic [OPC_W-1:0] OPC_BEQ     = 6'd4;
  localparam logic [OPC_W-1:0] OPC_BNE     = 6'd5;
  localparam logic [OPC_W-1:0] OPC_BLEZ    = 6'd6;
  localparam logic [OPC_W-1:0] OPC_BGTZ    = 6'd7;

  typedef enum logic [2:0] {
    K_NONE,
    K_EQ,
    K_SIGN,
    K_LEZ,
    K_JIMM,
    K_JREG
  } kind_e;

  typedef struct packed {
    kind_e      kind;
    logic       invert;
    logic       link;
    logic       link_rd;
  } dec_t;
endpackage

// File: rtl/bru_decode.sv
module bru_decode
  import bru_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] instr,
  output dec_t            dec
);
  logic [OPC_W-1:0] opc;
  logic [4:0]       rt_f;
  logic [5:0]       fn_f;

  assign opc  = instr[31:26];
  assign rt_f = instr[20:16];
  assign fn_f = instr[5:0];

  always_comb begin
    dec = '{kind: K_NONE, invert: 1'b0, link: 1'b0, link_rd: 1'b0};
    unique case (opc)
      OPC_SPECIAL: begin
        if (fn_f[5:1] == 5'b00100) begin
          dec.kind    = K_JREG;
          dec.link    = fn_f[0];
          dec.link_rd = fn_f[0];
        end
      end
      OPC_REGIMM: begin
        if (rt_f[3:1] == 3'b000) begin
          dec.kind   = K_SIGN;
          dec.invert = rt_f[0];
          dec.link   = rt_f[4];
        end
      end
      OPC_J, OPC_JAL: begin
        dec.kind = K_JIMM;
        dec.link = opc[0];
      end
      OPC_BEQ, OPC_BNE: begin
        dec.kind   = K_EQ;
        dec.invert = opc[0];
      end
      OPC_BLEZ, OPC_BGTZ: begin
        dec.kind   = K_LEZ;
        dec.invert = opc[0];
      end
      default: dec.kind = K_NONE;
    endcase
  end
endmodule

// File: rtl/bru_cond.sv
module bru_cond
  import bru_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  dec_t            dec,
  input  logic [XLEN-1:0] op_a,
  input  logic [XLEN-1:0] op_b,
  output logic            redirect
);
  logic is_eq;
  logic is_neg;
  logic is_zero;

  assign is_eq   = (op_a == op_b);
  assign is_neg  = op_a[XLEN-1];
  assign is_zero = (op_a == '0);

  always_comb begin
    unique case (dec.kind)
      K_EQ:    redirect = is_eq ^ dec.invert;
      K_SIGN:  redirect = is_neg ^ dec.invert;
      K_LEZ:   redirect = (is_neg | is_zero) ^ dec.invert;
      K_JIMM:  redirect = 1'b1;
      K_JREG:  redirect = 1'b1;
      default: redirect = 1'b0;
    endcase
  end
endmodule

// File: rtl/bru_target.sv
module bru_target
  import bru_pkg::*;
#(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned ADDR_W = 12
) (
  input  dec_t              dec,
  input  logic [XLEN-1:0]   instr,
  input  logic [XLEN-1:0]   op_a,
  input  logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] jump_pc,
  output logic [ADDR_W-1:0] seq_pc,
  output logic [ADDR_W-1:0] ret_pc
);
  localparam logic [ADDR_W-1:0] WORD_MASK = {{(ADDR_W-2){1'b1}}, 2'b00};
  localparam logic [ADDR_W-1:0] STEP4     = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] STEP8     = ADDR_W'(8);

  logic [XLEN-1:0]   off_full;
  logic [ADDR_W-1:0] pc_plus4;
  logic [ADDR_W-1:0] rel_pc;
  logic [ADDR_W-1:0] abs_pc;
  logic [ADDR_W-1:0] reg_pc;

  assign off_full = {{(XLEN-18){instr[15]}}, instr[15:0], 2'b00};
  assign pc_plus4 = pc + STEP4;
  assign rel_pc   = (pc_plus4 + off_full[ADDR_W-1:0]) & WORD_MASK;
  assign abs_pc   = {instr[ADDR_W-3:0], 2'b00};
  assign reg_pc   = op_a[ADDR_W-1:0] & WORD_MASK;
  assign seq_pc   = pc_plus4 & WORD_MASK;
  assign ret_pc   = (pc + STEP8) & WORD_MASK;

  always_comb begin
    unique case (dec.kind)
      K_JIMM:  jump_pc = abs_pc;
      K_JREG:  jump_pc = reg_pc;
      default: jump_pc = rel_pc;
    endcase
  end
endmodule

// File: rtl/branch_unit.sv
module branch_unit
  import bru_pkg::*;
#(
  parameter int unsigned XLEN     = 32,
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned RIDX_W   = 5,
  parameter int unsigned LINK_REG = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [XLEN-1:0]   instr,
  input  logic [XLEN-1:0]   op_a,
  input  logic [XLEN-1:0]   op_b,
  input  logic [ADDR_W-1:0] pc,
  output logic              out_valid,
  output logic              taken,
  output logic [ADDR_W-1:0] next_pc,
  output logic              link_we,
  output logic [RIDX_W-1:0] link_idx,
  output logic [ADDR_W-1:0] link_val
);
  localparam logic [RIDX_W-1:0] RA_IDX = RIDX_W'(LINK_REG);

  dec_t              dec;
  logic              redirect;
  logic [ADDR_W-1:0] jump_pc;
  logic [ADDR_W-1:0] seq_pc;
  logic [ADDR_W-1:0] ret_pc;

  logic              taken_d;
  logic [ADDR_W-1:0] next_pc_d;
  logic              link_we_d;
  logic [RIDX_W-1:0] link_idx_d;
  logic [ADDR_W-1:0] link_val_d;

  bru_decode #(.XLEN(XLEN)) u_dec (
    .instr (instr),
    .dec   (dec)
  );

  bru_cond #(.XLEN(XLEN)) u_cond (
    .dec      (dec),
    .op_a     (op_a),
    .op_b     (op_b),
    .redirect (redirect)
  );

  bru_target #(.XLEN(XLEN), .ADDR_W(ADDR_W)) u_tgt (
    .dec     (dec),
    .instr   (instr),
    .op_a    (op_a),
    .pc      (pc),
    .jump_pc (jump_pc),
    .seq_pc  (seq_pc),
    .ret_pc  (ret_pc)
  );

  always_comb begin
    taken_d    = redirect;
    next_pc_d  = redirect ? jump_pc : seq_pc;
    link_we_d  = dec.link;
    link_idx_d = '0;
    link_val_d = '0;
    if (dec.link) begin
      link_idx_d = dec.link_rd ? instr[11 +: RIDX_W] : RA_IDX;
      link_val_d = ret_pc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      taken     <= 1'b0;
      next_pc   <= '0;
      link_we   <= 1'b0;
      link_idx  <= '0;
      link_val  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        taken    <= taken_d;
        next_pc  <= next_pc_d;
        link_we  <= link_we_d;
        link_idx <= link_idx_d;
        link_val <= link_val_d;
      end
    end
  end
endmodule

// File: rtl/branch_unit_chk.sv
module branch_unit_chk #(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned RIDX_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [XLEN-1:0]   instr,
  input logic [XLEN-1:0]   op_a,
  input logic [ADDR_W-1:0] pc,
  input logic              out_valid,
  input logic              taken,
  input logic [ADDR_W-1:0] next_pc,
  input logic              link_we,
  input logic [RIDX_W-1:0] link_idx,
  input logic [ADDR_W-1:0] link_val
);
  // R2
  valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(next_pc) && $stable(taken) && $stable(link_we)
                   && $stable(link_idx) && $stable(link_val)));

  // R9
  seq_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (taken || next_pc == (($past(pc) + ADDR_W'(4)) & ~ADDR_W'(3))));

  // R10
  no_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !link_we |-> (link_idx == '0 && link_val == '0));

  // R6
  regimm_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && instr[31:26] == 6'd1 && instr[20] && instr[19:17] == 3'b000)
      |=> (link_we && link_idx == RIDX_W'(31)
           && link_val == (($past(pc) + ADDR_W'(8)) & ~ADDR_W'(3))));

  // R8
  jreg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && instr[31:26] == 6'd0 && instr[5:1] == 5'b00100)
      |=> (taken && next_pc == ($past(op_a[ADDR_W-1:0]) & ~ADDR_W'(3))));

  // R7
  jimm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && instr[31:27] == 5'b00001)
      |=> (taken && next_pc == {$past(instr[ADDR_W-3:0]), 2'b00}));
endmodule

bind branch_unit branch_unit_chk #(.XLEN(XLEN), .ADDR_W(ADDR_W), .RIDX_W(RIDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .instr     (instr),
  .op_a      (op_a),
  .pc        (pc),
  .out_valid (out_valid),
  .taken     (taken),
  .next_pc   (next_pc),
  .link_we   (link_we),
  .link_idx  (link_idx),
  .link_val  (link_val)
);

// File: tb/branch_unit_tb.sv
module branch_unit_tb;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] instr;
  logic [31:0] op_a;
  logic [31:0] op_b;
  logic [11:0] pc;
  logic        out_valid;
  logic        taken;
  logic [11:0] next_pc;
  logic        link_we;
  logic [4:0]  link_idx;
  logic [11:0] link_val;

  int checks;
  int errors;
  int cycles;
  bit done;

  branch_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .op_a(op_a), .op_b(op_b), .pc(pc), .out_valid(out_valid),
    .taken(taken), .next_pc(next_pc), .link_we(link_we),
    .link_idx(link_idx), .link_val(link_val)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000 && !done) begin
      done = 1'b1;
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run hung, actual cycles %0d expected below 190000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [31:0] mk(input logic [5:0] opc, input logic [4:0] rs,
                                     input logic [4:0] rt, input logic [15:0] imm);
    return {opc, rs, rt, imm};
  endfunction

  function automatic string tag_of(input logic [31:0] w);
    case (w[31:26])
      6'd0:       return (w[5:1] == 5'b00100) ? "R8" : "R9";
      6'd1:       return (w[19:17] != 3'b000) ? "R9" : (w[20] ? "R6" : "R4");
      6'd2, 6'd3: return "R7";
      6'd4, 6'd5: return "R3";
      6'd6, 6'd7: return "R5";
      default:    return "R9";
    endcase
  endfunction

  task automatic compare(input string tag, input logic act_v, input logic act_t,
                         input logic [11:0] act_pc, input logic act_we,
                         input logic [4:0] act_idx, input logic [11:0] act_lv,
                         input logic exp_v, input logic exp_t,
                         input logic [11:0] exp_pc, input logic exp_we,
                         input logic [4:0] exp_idx, input logic [11:0] exp_lv);
    checks = checks + 1;
    if (act_v !== exp_v || act_t !== exp_t || act_pc !== exp_pc ||
        act_we !== exp_we || act_idx !== exp_idx || act_lv !== exp_lv) begin
      errors = errors + 1;
      $display("FAIL %s: actual v=%0b t=%0b pc=%h we=%0b idx=%0d lv=%h expected v=%0b t=%0b pc=%h we=%0b idx=%0d lv=%h",
               tag, act_v, act_t, act_pc, act_we, act_idx, act_lv,
               exp_v, exp_t, exp_pc, exp_we, exp_idx, exp_lv);
    end
  endtask

  task automatic apply(input logic [31:0] w, input logic [31:0] a,
                       input logic [31:0] b, input logic [11:0] p);
    logic        et;
    logic [11:0] epc;
    logic        ewe;
    logic [4:0]  eidx;
    logic [11:0] elv;
    logic [31:0] rel;
    logic [4:0]  rt;
    @(negedge clk);
    in_valid = 1'b1; instr = w; op_a = a; op_b = b; pc = p;
    rel  = 32'(p) + 32'd4 + ({{16{w[15]}}, w[15:0]} * 32'd4);
    et   = 1'b0;
    epc  = rel[11:0] & 12'hFFC;
    ewe  = 1'b0;
    eidx = 5'd0;
    rt   = w[20:16];
    case (w[31:26])
      6'd0: if (w[5:0] == 6'd8 || w[5:0] == 6'd9) begin
              et = 1'b1; epc = a[11:0] & 12'hFFC;
              if (w[5:0] == 6'd9) begin ewe = 1'b1; eidx = w[15:11]; end
            end
      6'd1: if (rt == 5'd0 || rt == 5'd1 || rt == 5'd16 || rt == 5'd17) begin
              et = rt[0] ? ($signed(a) >= 0) : ($signed(a) < 0);
              if (rt[4]) begin ewe = 1'b1; eidx = 5'd31; end
            end
      6'd2: begin et = 1'b1; epc = (w[11:0] << 2) & 12'hFFC; end
      6'd3: begin et = 1'b1; epc = (w[11:0] << 2) & 12'hFFC; ewe = 1'b1; eidx = 5'd31; end
      6'd4: et = (a == b);
      6'd5: et = (a != b);
      6'd6: et = ($signed(a) <= 0);
      6'd7: et = ($signed(a) > 0);
      default: et = 1'b0;
    endcase
    if (!et) epc = (p + 12'd4) & 12'hFFC;
    elv = ewe ? ((p + 12'd8) & 12'hFFC) : 12'h000;
    @(negedge clk);
    in_valid = 1'b0;
    compare(tag_of(w), out_valid, taken, next_pc, link_we, link_idx, link_val,
            1'b1, et, epc, ewe, eidx, elv);
    if (!ewe) begin
      checks = checks + 1;
      if (link_idx !== 5'd0 || link_we !== 1'b0) begin
        errors = errors + 1;
        $display("FAIL R10: actual we=%0b idx=%0d expected we=0 idx=0", link_we, link_idx);
      end
    end
  endtask

  logic [31:0] avals [6];
  logic [15:0] imms  [6];

  initial begin
    logic        ht;
    logic [11:0] hpc;
    logic        hwe;
    logic [4:0]  hidx;
    logic [11:0] hlv;
    checks = 0; errors = 0; cycles = 0; done = 1'b0;
    avals[0] = 32'h0000_0000; avals[1] = 32'h0000_0001; avals[2] = 32'hFFFF_FFFF;
    avals[3] = 32'h7FFF_FFFF; avals[4] = 32'h8000_0000; avals[5] = 32'h1234_5FFE;
    imms[0] = 16'h0000; imms[1] = 16'hFFFF; imms[2] = 16'h7FFF;
    imms[3] = 16'h8000; imms[4] = 16'h0010; imms[5] = 16'hFFFE;
    rst_n = 1'b0; in_valid = 1'b0; instr = 32'h0C00_0123; op_a = 32'h55; op_b = 0; pc = 12'h444;
    repeat (3) @(negedge clk);
    // R1 during reset
    compare("R1", out_valid, taken, next_pc, link_we, link_idx, link_val,
            1'b0, 1'b0, 12'h0, 1'b0, 5'd0, 12'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1 after release with no valid input
    compare("R1", out_valid, taken, next_pc, link_we, link_idx, link_val,
            1'b0, 1'b0, 12'h0, 1'b0, 5'd0, 12'h0);

    // R3 wrap: forward past the top, backward below zero, not-taken at top (R9)
    apply(mk(6'd4, 5'd1, 5'd2, 16'h0000), 32'd7, 32'd7, 12'hFFC);
    apply(mk(6'd4, 5'd1, 5'd2, 16'hFFFE), 32'd7, 32'd7, 12'h000);
    apply(mk(6'd5, 5'd1, 5'd2, 16'h0004), 32'd3, 32'd9, 12'hFF0);
    apply(mk(6'd5, 5'd1, 5'd2, 16'h0004), 32'd3, 32'd3, 12'hFFC);
    // R6 link at the top wraps to 0x004
    apply(mk(6'd1, 5'd1, 5'd16, 16'h0001), 32'd0, 32'd0, 12'hFFC);

    for (int k = 0; k < 18; k++) begin
      logic [11:0] p;
      p = (k == 17) ? 12'hFFC : 12'((k * 32'h0E4) & 32'hFFC);
      for (int ai = 0; ai < 6; ai++) begin
        for (int bi = 0; bi < 2; bi++) begin
          logic [31:0] a;
          logic [31:0] b;
          logic [15:0] im;
          logic [4:0]  rd;
          a  = avals[ai];
          b  = bi[0] ? (a ^ 32'h1) : a;
          im = imms[(ai + k) % 6];
          rd = 5'((ai * 5 + k) & 31);
          apply(mk(6'd4, 5'd3, 5'd4, im), a, b, p);                 // R3
          apply(mk(6'd5, 5'd3, 5'd4, im), a, b, p);                 // R3
          apply(mk(6'd1, 5'd3, 5'd0, im), a, b, p);                 // R4
          apply(mk(6'd1, 5'd3, 5'd1, im), a, b, p);                 // R4
          apply(mk(6'd1, 5'd3, 5'd16, im), a, b, p);                // R6
          apply(mk(6'd1, 5'd3, 5'd17, im), a, b, p);                // R6
          apply(mk(6'd6, 5'd3, 5'd0, im), a, b, p);                 // R5
          apply(mk(6'd7, 5'd3, 5'd0, im), a, b, p);                 // R5
          apply({6'd2, 10'(k * 37 + ai), im}, a, b, p);             // R7
          apply({6'd3, 10'(k * 53 + bi), im}, a, b, p);             // R7
          apply({6'd0, 5'd3, 5'd0, rd, 5'd0, 6'd8}, a + 32'(p), b, p); // R8
          apply({6'd0, 5'd3, 5'd0, rd, 5'd0, 6'd9}, a + 32'(p), b, p); // R8
          apply({6'd0, 5'd3, 5'd4, rd, 5'd0, 6'h20}, a, b, p);      // R9
          apply(mk(6'd1, 5'd3, 5'd2, im), a, b, p);                 // R9
          apply(mk(6'd8, 5'd3, 5'd4, im), a, b, p);                 // R9
        end
      end
    end

    // R2: with in_valid low, changing inputs must leave results untouched
    apply(mk(6'd3, 5'd0, 5'd0, 16'h0155), 32'd0, 32'd0, 12'h200);
    ht = taken; hpc = next_pc; hwe = link_we; hidx = link_idx; hlv = link_lv_copy();
    for (int r = 0; r < 4; r++) begin
      @(negedge clk);
      instr = mk(6'd4, 5'd0, 5'd0, 16'h0040); op_a = 32'(r); op_b = 32'(r); pc = 12'(r * 16);
      @(negedge clk);
      compare("R2", out_valid, taken, next_pc, link_we, link_idx, link_val,
              1'b0, ht, hpc, hwe, hidx, hlv);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  function automatic logic [11:0] link_lv_copy();
    return link_val;
  endfunction
endmodule